// File: doc/BRIEF.md
# Framebuffer Scan Address Generator

This block drives a fixed 640x480 true-colour panel from an image held in memory. Software gives it the memory location of the image and a control word through two write-only words. The block then runs horizontal and vertical scan counters over a full frame, including blanking and sync intervals. For every visible pixel it issues one word read, and it turns each returned 32-bit word into separate 8-bit red, green and blue outputs. These outputs are aligned with a data-enable strobe and with active-low sync pulses.

Each image row occupies a stride of 1024 words, of which only the leading 640 are read. Only the upper bits of the base address are kept, so the image always starts on a 2 MiB boundary. A control bit reverses both scan directions, which turns the picture upside down and mirrors it (a 180-degree rotation). Memory is reached through a plain request/valid pair with a fixed read latency. New settings are held in staging registers and are copied into the working set only at the frame boundary.

Top module: `fb_scan_gen`

## Requirements
- R1: After reset both words are zero. The display is therefore off: there is no `mem_req`, the colour outputs are zero, `de` is low and both sync outputs are high until the scan begins.
- R2: A write with `reg_sel`=0 sets the base address. A write with `reg_sel`=1 sets control, where bit 0 enables and bit 1 rotates. All other control bits have no effect, and a control write leaves the base unchanged.
- R3: When enabled and not rotated, one request is made per visible pixel in row-major order, at byte address {base[31:21], row[8:0], col[9:0], 2'b00}. Columns never reach the 384 unused words of each 1024-word row.
- R4: With rotation set, the address uses row' = V_ACTIVE-1-row and col' = H_ACTIVE-1-col, so the first fetch of a frame is the last pixel of the image.
- R5: Base-address bits 20:0 have no effect on any fetch address.
- R6: While disabled, no request is issued in the whole frame, and the colour outputs stay zero while `de` still marks the visible region.
- R7: Writes made during a frame do not change that frame. All settings take effect from the first pixel of the next frame.
- R8: Colour comes from the returned word with red from bits 23:16, green from bits 15:8 and blue from bits 7:0. Bits 31:24 are ignored.
- R9: `de` is high for exactly H_ACTIVE cycles per line and H_ACTIVE*V_ACTIVE cycles per frame. Outside `de` the colour outputs are zero.
- R10: `hsync_n` is low for H_SYNC cycles per line. `vsync_n` is low for V_SYNC whole lines per frame.
- R11: Memory data is captured only on `mem_rvalid`. The pixel for a request appears on the outputs exactly RD_LAT+1 cycles after that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Word select: 0 base address, 1 control |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Pixel word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid, RD_LAT cycles after the request |
| mem_rdata | input | 32 | Read data word |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high in the visible region |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |

## Verification
The bench builds the block with an 8x4 visible area inside a 14x8 total frame (2-cycle porches and sync, one-line front porch and sync, two-line back porch) and RD_LAT=2. The row and column field widths are left at 9 and 10 bits. A whole frame then lasts 112 cycles. This brings many frame boundaries, rotation flips, mid-frame writes and the full scan order within a short run, while the address layout stays the same as in the full-size build.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;

  // Timing flags carried alongside a pixel through the fetch pipeline.
  typedef struct packed {
    logic vis;
    logic hs_n;
    logic vs_n;
  } scan_tag_t;

  localparam scan_tag_t TAG_IDLE = '{vis: 1'b0, hs_n: 1'b1, vs_n: 1'b1};

endpackage

// File: rtl/fb_scan_regs.sv
module fb_scan_regs #(
  parameter int BASE_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic                 reg_sel,
  input  logic [31:0]          reg_wdata,
  input  logic                 frame_wrap,
  output logic                 act_en,
  output logic                 act_rot,
  output logic [BASE_BITS-1:0] act_base
);

  logic [BASE_BITS-1:0] base_q, base_d;
  logic                 en_q, en_d, rot_q, rot_d;
  logic [BASE_BITS-1:0] abase_q, abase_d;
  logic                 aen_q, aen_d, arot_q, arot_d;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[31-BASE_BITS:2]};

  // Staging registers written by software.
  always_comb begin
    base_d = base_q;
    en_d   = en_q;
    rot_d  = rot_q;
    if (reg_we && !reg_sel) base_d = reg_wdata[31 -: BASE_BITS];
    if (reg_we &&  reg_sel) begin
      en_d  = reg_wdata[0];
      rot_d = reg_wdata[1];
    end
  end

  // Working set: copied only at the frame boundary.
  always_comb begin
    abase_d = abase_q;
    aen_d   = aen_q;
    arot_d  = arot_q;
    if (frame_wrap) begin
      abase_d = base_d;
      aen_d   = en_d;
      arot_d  = rot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      en_q    <= 1'b0;
      rot_q   <= 1'b0;
      abase_q <= '0;
      aen_q   <= 1'b0;
      arot_q  <= 1'b0;
    end else begin
      base_q  <= base_d;
      en_q    <= en_d;
      rot_q   <= rot_d;
      abase_q <= abase_d;
      aen_q   <= aen_d;
      arot_q  <= arot_d;
    end
  end

  assign act_en   = aen_q;
  assign act_rot  = arot_q;
  assign act_base = abase_q;

endmodule

// File: rtl/fb_scan_timing.sv
module fb_scan_timing
  import fb_scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output scan_tag_t     tag,
  output logic          frame_wrap
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_VIS  = VW'(V_ACTIVE);
  localparam logic [HW-1:0] H_SS   = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] H_SE   = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_SS   = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] V_SE   = VW'(V_ACTIVE + V_FP + V_SYNC);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          line_end;

  assign line_end = (h_q == H_LAST);

  always_comb begin
    h_d = line_end ? '0 : h_q + 1'b1;
    v_d = v_q;
    if (line_end) v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign h_cnt      = h_q;
  assign v_cnt      = v_q;
  assign frame_wrap = line_end && (v_q == V_LAST);
  assign tag.vis    = (h_q < H_VIS) && (v_q < V_VIS);
  assign tag.hs_n   = !((h_q >= H_SS) && (h_q < H_SE));
  assign tag.vs_n   = !((v_q >= V_SS) && (v_q < V_SE));

endmodule

// File: rtl/fb_scan_addr.sv
module fb_scan_addr #(
  parameter int H_ACTIVE  = 640,
  parameter int V_ACTIVE  = 480,
  parameter int COL_BITS  = 10,
  parameter int ROW_BITS  = 9,
  parameter int HW        = 10,
  parameter int VW        = 10,
  localparam int BASE_BITS = 32 - ROW_BITS - COL_BITS - 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HW-1:0]        h_cnt,
  input  logic [VW-1:0]        v_cnt,
  input  logic                 vis,
  input  logic                 act_en,
  input  logic                 act_rot,
  input  logic [BASE_BITS-1:0] act_base,
  output logic                 mem_req,
  output logic [31:0]          mem_addr
);

  localparam logic [31:0] COL_LAST = 32'(H_ACTIVE - 1);
  localparam logic [31:0] ROW_LAST = 32'(V_ACTIVE - 1);

  logic [31:0] col_w, row_w, addr_d;
  logic        fetch;
  logic        req_q;
  logic [31:0] addr_q;

  logic unused_hi;
  assign unused_hi = ^{col_w[31:COL_BITS], row_w[31:ROW_BITS]};

  always_comb begin
    col_w  = act_rot ? (COL_LAST - 32'(h_cnt)) : 32'(h_cnt);
    row_w  = act_rot ? (ROW_LAST - 32'(v_cnt)) : 32'(v_cnt);
    addr_d = {act_base, row_w[ROW_BITS-1:0], col_w[COL_BITS-1:0], 2'b00};
    fetch  = act_en && vis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= fetch;
      if (fetch) addr_q <= addr_d;
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;

endmodule

// File: rtl/fb_scan_unpack.sv
module fb_scan_unpack
  import fb_scan_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  scan_tag_t   tag_in,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        de,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic [7:0]  red,
  output logic [7:0]  green,
  output logic [7:0]  blue
);

  scan_tag_t   pipe_q [RD_LAT+1];
  scan_tag_t   out_tag_q;
  logic [23:0] rgb_q, rgb_d;

  logic unused_pad;
  assign unused_pad = ^mem_rdata[31:24];

  // Delay the timing flags by one request stage plus the read latency.
  generate
    for (genvar s = 0; s <= RD_LAT; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= TAG_IDLE;
        else if (s == 0) pipe_q[s] <= tag_in;
        else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    rgb_d = mem_rvalid ? mem_rdata[23:0] : 24'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_tag_q <= TAG_IDLE;
      rgb_q     <= '0;
    end else begin
      out_tag_q <= pipe_q[RD_LAT];
      rgb_q     <= rgb_d;
    end
  end

  assign de      = out_tag_q.vis;
  assign hsync_n = out_tag_q.hs_n;
  assign vsync_n = out_tag_q.vs_n;
  assign red     = rgb_q[23:16];
  assign green   = rgb_q[15:8];
  assign blue    = rgb_q[7:0];

endmodule

// File: rtl/fb_scan_gen.sv
module fb_scan_gen
  import fb_scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int COL_BITS = 10,
  parameter int ROW_BITS = 9,
  parameter int RD_LAT   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic        de,
  output logic [7:0]  red,
  output logic [7:0]  green,
  output logic [7:0]  blue
);

  localparam int H_TOTAL   = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL   = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW        = $clog2(H_TOTAL);
  localparam int VW        = $clog2(V_TOTAL);
  localparam int BASE_BITS = 32 - ROW_BITS - COL_BITS - 2;

  logic [HW-1:0]        h_cnt;
  logic [VW-1:0]        v_cnt;
  scan_tag_t            tag;
  logic                 frame_wrap;
  logic                 act_en, act_rot;
  logic [BASE_BITS-1:0] act_base;

  fb_scan_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .tag(tag), .frame_wrap(frame_wrap)
  );

  fb_scan_regs #(.BASE_BITS(BASE_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .frame_wrap(frame_wrap),
    .act_en(act_en), .act_rot(act_rot), .act_base(act_base)
  );

  fb_scan_addr #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .COL_BITS(COL_BITS),
    .ROW_BITS(ROW_BITS), .HW(HW), .VW(VW)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .vis(tag.vis),
    .act_en(act_en), .act_rot(act_rot), .act_base(act_base),
    .mem_req(mem_req), .mem_addr(mem_addr)
  );

  fb_scan_unpack #(.RD_LAT(RD_LAT)) u_unpack (
    .clk(clk), .rst_n(rst_n), .tag_in(tag), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue)
  );

endmodule

// File: rtl/fb_scan_gen_chk.sv
module fb_scan_gen_chk #(
  parameter int H_ACTIVE  = 640,
  parameter int V_ACTIVE  = 480,
  parameter int COL_BITS  = 10,
  parameter int ROW_BITS  = 9,
  parameter int BASE_BITS = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mem_req,
  input logic [31:0]          mem_addr,
  input logic                 de,
  input logic [7:0]           red,
  input logic [7:0]           green,
  input logic [7:0]           blue,
  input logic                 frame_wrap,
  input logic                 act_en,
  input logic                 act_rot,
  input logic [BASE_BITS-1:0] act_base
);

  // R3: fetches are word aligned and stay inside the visible columns and rows.
  p_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_col_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(mem_addr[COL_BITS+1:2]) < H_ACTIVE));

  p_row_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(mem_addr[ROW_BITS+COL_BITS+1:COL_BITS+2]) < V_ACTIVE));

  // R6: a disabled working set issues no request on the next cycle.
  p_no_fetch_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> !mem_req);

  // R7: working settings only move at the frame boundary.
  p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> ($stable(act_en) && $stable(act_rot) && $stable(act_base)));

  // R9: colour outputs are black outside the visible region.
  p_black_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> ({red, green, blue} == 24'h0));

endmodule

bind fb_scan_gen fb_scan_gen_chk #(
  .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .COL_BITS(COL_BITS),
  .ROW_BITS(ROW_BITS), .BASE_BITS(BASE_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .de(de), .red(red), .green(green), .blue(blue), .frame_wrap(frame_wrap),
  .act_en(act_en), .act_rot(act_rot), .act_base(act_base)
);

// File: tb/fb_scan_gen_bench.sv
`timescale 1ns/1ps
module fb_scan_gen_bench;

  localparam int HA = 8, HFP = 2, HS = 2, HBP = 2;
  localparam int VA = 4, VFP = 1, VS = 1, VBP = 2;
  localparam int LAT = 2;
  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int FRAME = HT * VT;
  localparam int NPIX = HA * VA;
  localparam int NVEC = 6;

  // {base, control}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0000, 32'h0000_0001},
    {32'h1234_5678, 32'h0000_0001},
    {32'hFFE0_0000, 32'h0000_0003},
    {32'hA5A5_A5A5, 32'h0000_0002},
    {32'h0020_0000, 32'hFFFF_FFFD},
    {32'h8000_0001, 32'h0000_0003}
  };

  logic        clk, rst_n;
  logic        reg_we, reg_sel;
  logic [31:0] reg_wdata;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        hsync_n, vsync_n, de;
  logic [7:0]  red, green, blue;

  int n_checks = 0;
  int n_err    = 0;

  fb_scan_gen #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
    .COL_BITS(10), .ROW_BITS(9), .RD_LAT(LAT)
  ) u_fb_scan_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .de(de), .red(red), .green(green), .blue(blue)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {~a[9:2], a[27:20], a[19:12] ^ 8'h3C, a[9:2]};
  endfunction

  function automatic logic [31:0] exp_addr(int k, logic rot, logic [31:0] base);
    int row, col;
    logic [8:0] r9;
    logic [9:0] c10;
    row = k / HA;
    col = k % HA;
    if (rot) begin
      row = VA - 1 - row;
      col = HA - 1 - col;
    end
    r9  = 9'(row);
    c10 = 10'(col);
    return {base[31:21], r9, c10, 2'b00};
  endfunction

  function automatic string vec_tag(logic en, logic rot, logic [31:0] base, logic [31:0] ctrl);
    if (!en) return "R6";
    if (ctrl[31:2] != 0) return "R2";
    if (rot) return "R4";
    if (base[20:0] != 0) return "R5";
    return "R3";
  endfunction

  // Fixed-latency memory model.
  logic        pv [LAT];
  logic [31:0] pd [LAT];
  assign mem_rvalid = pv[LAT-1];
  assign mem_rdata  = pv[LAT-1] ? pd[LAT-1] : 32'hDEAD_BEEF;
  initial begin
    for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pd[i] = '0; end
    forever begin
      @(posedge clk);
      pv[0] <= mem_req;
      pd[0] <= mem_word(mem_addr);
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end

  task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_frame(logic en, logic rot, logic [31:0] base, string atag,
                           bit mid, logic [31:0] mb, logic [31:0] mc);
    int rq = 0, dq = 0, cyc = 0, t_req = -1, t_de = -1, mstep = 0;
    logic [31:0] a_bad = '0, a_exp = '0, ea;
    logic [23:0] p_bad = '0, p_exp = '0, ep;
    do @(negedge clk); while (vsync_n !== 1'b1);
    do @(negedge clk); while (vsync_n !== 1'b0);
    while (dq < NPIX && cyc < 3 * FRAME) begin
      @(negedge clk);
      cyc++;
      if (mem_req === 1'b1) begin
        ea = exp_addr(rq, rot, base);
        if (mem_addr !== ea && a_bad == a_exp) begin a_bad = mem_addr; a_exp = ea; end
        if (t_req < 0) t_req = cyc;
        rq++;
      end
      if (de === 1'b1) begin
        ep = en ? mem_word(exp_addr(dq, rot, base))[23:0] : 24'h0;
        if ({red, green, blue} !== ep && p_bad == p_exp) begin
          p_bad = {red, green, blue}; p_exp = ep;
        end
        if (t_de < 0) t_de = cyc;
        dq++;
      end else if ({red, green, blue} !== 24'h0 && p_bad == p_exp) begin
        p_bad = {red, green, blue}; p_exp = 24'h0;  // R9 black in blanking
      end
      if (mid) begin
        // R7: change every setting in the middle of the frame
        if (mstep == 0 && dq >= 3) begin
          reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = mb; mstep = 1;
        end else if (mstep == 1) begin
          reg_sel = 1'b1; reg_wdata = mc; mstep = 2;
        end else if (mstep == 2) begin
          reg_we = 1'b0; mstep = 3;
        end
      end
    end
    check(en ? "R3" : "R6", "request count", 64'(rq), 64'(en ? NPIX : 0));
    check(mid ? "R7" : atag, "fetch address", 64'(a_bad), 64'(a_exp));
    check("R8", "pixel colour", 64'(p_bad), 64'(p_exp));
    check("R9", "de cycles per frame", 64'(dq), 64'(NPIX));
    if (en) check("R11", "request to pixel delay", 64'(t_de - t_req), 64'(LAT + 1));
  endtask

  task automatic sync_check();
    int n;
    do @(negedge clk); while (vsync_n !== 1'b1);
    do @(negedge clk); while (vsync_n !== 1'b0);
    n = 0;
    while (vsync_n === 1'b0 && n < 2 * FRAME) begin @(negedge clk); n++; end
    check("R10", "vsync low cycles", 64'(n), 64'(VS * HT));
    do @(negedge clk); while (hsync_n !== 1'b0);
    n = 0;
    while (hsync_n === 1'b0 && n < HT) begin @(negedge clk); n++; end
    check("R10", "hsync low cycles", 64'(n), 64'(HS));
    n = 0;
    do begin @(negedge clk); n++; end while (hsync_n !== 1'b0 && n < 2 * HT);
    check("R10", "hsync period", 64'(n), 64'(HT - HS));
    do @(negedge clk); while (de !== 1'b1);
    n = 0;
    while (de === 1'b1 && n < HT) begin @(negedge clk); n++; end
    check("R9", "de run per line", 64'(n), 64'(HA));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", "mem_req in reset", 64'(mem_req), 64'(0));
    check("R1", "colour in reset", 64'({red, green, blue}), 64'(0));
    check("R1", "de/sync in reset", 64'({de, hsync_n, vsync_n}), 64'(3'b011));
    rst_n = 1'b1;
    // R1: display off without any write
    run_frame(1'b0, 1'b0, 32'h0, "R1", 1'b0, '0, '0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] b, c;
      b = VEC[i][63:32];
      c = VEC[i][31:0];
      wr(1'b0, b);
      wr(1'b1, c);
      run_frame(c[0], c[1], b, vec_tag(c[0], c[1], b, c), 1'b0, '0, '0);
    end

    // R7: mid-frame writes leave the running frame alone, then apply
    wr(1'b0, 32'h0040_0000);
    wr(1'b1, 32'h1);
    run_frame(1'b1, 1'b0, 32'h0040_0000, "R3", 1'b0, '0, '0);
    run_frame(1'b1, 1'b0, 32'h0040_0000, "R7", 1'b1, 32'h0060_0000, 32'h3);
    run_frame(1'b1, 1'b1, 32'h0060_0000, "R7", 1'b0, '0, '0);

    // R2: a control write keeps the base
    wr(1'b1, 32'h1);
    run_frame(1'b1, 1'b0, 32'h0060_0000, "R2", 1'b0, '0, '0);

    sync_check();

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule